// File: doc/BRIEF.md
# Power-Down Entry Spacing Checker

This block sits beside the command scheduler of a DRAM controller and answers one question each cycle: may a power-down or self-refresh entry command go onto the command bus now? It watches every command the scheduler puts on the bus and keeps the kind of the latest one and how many cycles have passed since it was issued. When the scheduler raises an entry request, the block looks up the minimum spacing that the latest command demands and reports whether the request may go, how many cycles remain, or that no entry can legally follow that command at all.

Each spacing is a composite of synthesis-time cycle counts. A read waits for its data to leave and one extra clock. A write waits for its data and for write recovery, with one further clock when auto-precharge is set. Refresh, precharge and the exits from low-power states each have their own single figure. Only the most recent command is considered; bank history, bus arbitration and tracking of the power state belong elsewhere.

A command is issued in the cycle in which `cmd_vld` is high. The distance of a request in cycle c from a command issued in cycle c0 is c - c0.

Top module: `pdn_entry_gate`

## Requirements
- R1: After reset, before any command has been issued, a request of kind 0, 1 or 2 gives `entry_ok`=1, `wait_left`=0 and `seq_err`=0.
- R2: When the latest command is a read (opcode 1) or a read with auto-precharge (opcode 2), a request is allowed only at distance of at least T_RL+T_BURST+1; at a smaller distance d, `entry_ok`=0 and `wait_left` = spacing - d.
- R3: When the latest command is a write (opcode 3), the spacing is T_WL+T_BURST+T_WR, with the same allowed and waiting behaviour as R2.
- R4: When the latest command is a write with auto-precharge (opcode 4), the spacing is T_WL+T_BURST+T_WR+1.
- R5: When the latest command is an all-bank refresh (opcode 7), the spacing is T_RFC.
- R6: When the latest command is an exit from active or precharge power-down (opcodes 8 and 9), the spacing is T_XP; after a self-refresh exit (opcode 10) it is T_XS.
- R7: When the latest command is a single-bank or all-bank precharge (opcodes 5 and 6), the spacing is T_RP.
- R8: When the latest command has any other opcode (0 row activate, 11 to 15 including the entry commands 12, 13 and 14), a request gives `seq_err`=1, `entry_ok`=0 and `wait_left`=0.
- R9: Request kinds 0 (active power-down entry), 1 (precharge power-down entry) and 2 (self-refresh entry) are all checked by the same rules; with `req_vld`=0 or kind 3 all three outputs are 0.
- R10: A newer command replaces the older one: the spacing and distance always come from the latest issued command alone.
- R11: A command issued in the same cycle as a request does not affect that cycle's verdict; it applies from the next cycle on.
- R12: The distance saturates at the largest spacing, so a request after any length of idle time behind a legal command is allowed.
- R13: While a request stays present and no new command is issued, `wait_left` drops by exactly one per cycle until the request is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | A command is issued on the bus this cycle |
| cmd_op | input | 4 | Opcode of the issued command (encoding in R2 to R8) |
| req_vld | input | 1 | The scheduler asks to issue an entry command this cycle |
| req_kind | input | 2 | Entry kind: 0 active power-down, 1 precharge power-down, 2 self-refresh, 3 none |
| entry_ok | output | 1 | The requested entry may be issued this cycle |
| wait_left | output | SP_W | Cycles still to wait before the request is allowed |
| seq_err | output | 1 | No entry may follow the latest command |

## Verification
The bench builds the block with T_RL=5, T_WL=4, T_BURST=4, T_WR=6, T_RFC=30, T_XP=3, T_XS=40 and T_RP=5, which give every predecessor class its own spacing (10, 14, 15, 30, 3, 40, 5), so a wrong table entry or a swapped class shows up as a wrong wait count. With the largest spacing at 40 the distance register is six bits wide, so an idle gap of 100 cycles reaches past the point where an unsaturated count would wrap below 40. Every spacing is scanned cycle by cycle from distance 1 to the first allowed cycle, which also follows the countdown of the remaining wait.

// File: rtl/pdn_gate_pkg.sv
package pdn_gate_pkg;

   localparam int OP_W = 4;

   // command opcodes seen on the bus
   localparam logic [OP_W-1:0] OP_ROW_OPEN = 4'h0;
   localparam logic [OP_W-1:0] OP_RD       = 4'h1;
   localparam logic [OP_W-1:0] OP_RD_AP    = 4'h2;
   localparam logic [OP_W-1:0] OP_WR       = 4'h3;
   localparam logic [OP_W-1:0] OP_WR_AP    = 4'h4;
   localparam logic [OP_W-1:0] OP_PRE_ONE  = 4'h5;
   localparam logic [OP_W-1:0] OP_PRE_ALL  = 4'h6;
   localparam logic [OP_W-1:0] OP_REF_ALL  = 4'h7;
   localparam logic [OP_W-1:0] OP_PDX_ACT  = 4'h8;
   localparam logic [OP_W-1:0] OP_PDX_PRE  = 4'h9;
   localparam logic [OP_W-1:0] OP_SRX      = 4'hA;

   // entry request kinds
   localparam logic [1:0] KIND_PDE_ACT = 2'd0;
   localparam logic [1:0] KIND_PDE_PRE = 2'd1;
   localparam logic [1:0] KIND_SRE     = 2'd2;
   localparam logic [1:0] KIND_NONE    = 2'd3;

   typedef enum logic [2:0] {
      PC_READ,
      PC_WRITE,
      PC_WRITE_AP,
      PC_REFRESH,
      PC_PD_EXIT,
      PC_SR_EXIT,
      PC_PRECHARGE,
      PC_ILLEGAL
   } pred_class_e;

   function automatic pred_class_e classify_op(input logic [OP_W-1:0] op);
      case (op)
         OP_RD, OP_RD_AP:          return PC_READ;
         OP_WR:                    return PC_WRITE;
         OP_WR_AP:                 return PC_WRITE_AP;
         OP_REF_ALL:               return PC_REFRESH;
         OP_PDX_ACT, OP_PDX_PRE:   return PC_PD_EXIT;
         OP_SRX:                   return PC_SR_EXIT;
         OP_PRE_ONE, OP_PRE_ALL:   return PC_PRECHARGE;
         default:                  return PC_ILLEGAL;
      endcase
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pdn_spacing_lut.sv
module pdn_spacing_lut
   import pdn_gate_pkg::*;
#(
   parameter int T_RL    = 5,
   parameter int T_WL    = 4,
   parameter int T_BURST = 4,
   parameter int T_WR    = 6,
   parameter int T_RFC   = 30,
   parameter int T_XP    = 3,
   parameter int T_XS    = 40,
   parameter int T_RP    = 5,
   parameter int SP_W    = 6
) (
   input  pred_class_e       cls,
   output logic [SP_W-1:0]   spacing,
   output logic              legal
);

   localparam int SP_READ  = T_RL + T_BURST + 1;
   localparam int SP_WRITE = T_WL + T_BURST + T_WR;
   localparam int SP_WR_AP = SP_WRITE + 1;

   always_comb begin
      legal   = 1'b1;
      spacing = '0;
      case (cls)
         PC_READ:      spacing = SP_W'(SP_READ);
         PC_WRITE:     spacing = SP_W'(SP_WRITE);
         PC_WRITE_AP:  spacing = SP_W'(SP_WR_AP);
         PC_REFRESH:   spacing = SP_W'(T_RFC);
         PC_PD_EXIT:   spacing = SP_W'(T_XP);
         PC_SR_EXIT:   spacing = SP_W'(T_XS);
         PC_PRECHARGE: spacing = SP_W'(T_RP);
         default:      legal   = 1'b0;
      endcase
   end

endmodule

// File: rtl/pdn_history.sv
module pdn_history
   import pdn_gate_pkg::*;
#(
   parameter int T_RL          = 5,
   parameter int T_WL          = 4,
   parameter int T_BURST       = 4,
   parameter int T_WR          = 6,
   parameter int T_RFC         = 30,
   parameter int T_XP          = 3,
   parameter int T_XS          = 40,
   parameter int T_RP          = 5,
   parameter int SP_W          = 6,
   parameter int AGE_CAP       = 40,
   parameter int STORE_SPACING = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_vld,
   input  logic [OP_W-1:0]   cmd_op,
   output logic              hist_vld,
   output logic [SP_W-1:0]   spacing,
   output logic              legal,
   output logic [SP_W-1:0]   age
);

   localparam logic [SP_W-1:0] CAP = SP_W'(AGE_CAP);

   pred_class_e in_cls;
   assign in_cls = classify_op(cmd_op);

   generate
      if (STORE_SPACING != 0) begin : g_store_spacing
         // decode at issue time, keep the resolved spacing
         logic [SP_W-1:0] nxt_sp;
         logic            nxt_legal;
         logic [SP_W-1:0] sp_q;
         logic            legal_q;

         pdn_spacing_lut #(
            .T_RL(T_RL), .T_WL(T_WL), .T_BURST(T_BURST), .T_WR(T_WR),
            .T_RFC(T_RFC), .T_XP(T_XP), .T_XS(T_XS), .T_RP(T_RP), .SP_W(SP_W)
         ) u_lut (
            .cls(in_cls), .spacing(nxt_sp), .legal(nxt_legal)
         );

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sp_q    <= '0;
               legal_q <= 1'b1;
            end else if (cmd_vld) begin
               sp_q    <= nxt_sp;
               legal_q <= nxt_legal;
            end
         end

         assign spacing = sp_q;
         assign legal   = legal_q;
      end else begin : g_store_class
         // keep only the class, decode on the request path
         pred_class_e cls_q;

         always_ff @(posedge clk) begin
            if (!rst_n)       cls_q <= PC_ILLEGAL;
            else if (cmd_vld) cls_q <= in_cls;
         end

         pdn_spacing_lut #(
            .T_RL(T_RL), .T_WL(T_WL), .T_BURST(T_BURST), .T_WR(T_WR),
            .T_RFC(T_RFC), .T_XP(T_XP), .T_XS(T_XS), .T_RP(T_RP), .SP_W(SP_W)
         ) u_lut (
            .cls(cls_q), .spacing(spacing), .legal(legal)
         );
      end
   endgenerate

   // distance since the latest command, saturating at the largest spacing
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_vld <= 1'b0;
         age      <= '0;
      end else if (cmd_vld) begin
         hist_vld <= 1'b1;
         age      <= SP_W'(1);
      end else if (hist_vld && age < CAP) begin
         age      <= age + 1'b1;
      end
   end

   p_age_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld |=> (hist_vld && age == SP_W'(1)));

   p_age_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_vld && !cmd_vld && age == CAP) |=> (age == CAP));

   p_age_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_vld && !cmd_vld && age < CAP) |=> (age == $past(age) + 1'b1));

endmodule

// File: rtl/pdn_entry_eval.sv
module pdn_entry_eval
   import pdn_gate_pkg::*;
#(
   parameter int SP_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic [1:0]        req_kind,
   input  logic              hist_vld,
   input  logic [SP_W-1:0]   spacing,
   input  logic              legal,
   input  logic [SP_W-1:0]   age,
   output logic              entry_ok,
   output logic [SP_W-1:0]   wait_left,
   output logic              seq_err
);

   logic req_on;
   logic blocked;
   logic early;

   always_comb begin
      req_on    = req_vld && (req_kind != KIND_NONE);
      blocked   = hist_vld && !legal;
      early     = hist_vld && legal && (age < spacing);
      entry_ok  = req_on && !blocked && !early;
      seq_err   = req_on && blocked;
      wait_left = (req_on && early) ? (spacing - age) : '0;
   end

   p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(entry_ok && seq_err));

   p_ok_nowait_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_ok || seq_err) |-> (wait_left == '0));

   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_vld || req_kind == KIND_NONE) |-> (!entry_ok && !seq_err && wait_left == '0));

endmodule

// File: rtl/pdn_entry_gate.sv
module pdn_entry_gate
   import pdn_gate_pkg::*;
#(
   parameter int T_RL          = 5,
   parameter int T_WL          = 4,
   parameter int T_BURST       = 4,
   parameter int T_WR          = 6,
   parameter int T_RFC         = 30,
   parameter int T_XP          = 3,
   parameter int T_XS          = 40,
   parameter int T_RP          = 5,
   parameter int STORE_SPACING = 1,
   localparam int SP_MAX = max_of(max_of(max_of(T_RL + T_BURST + 1, T_WL + T_BURST + T_WR + 1),
                                         max_of(T_RFC, T_XP)),
                                  max_of(T_XS, T_RP)),
   localparam int SP_W   = $clog2(SP_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_vld,
   input  logic [OP_W-1:0]   cmd_op,
   input  logic              req_vld,
   input  logic [1:0]        req_kind,
   output logic              entry_ok,
   output logic [SP_W-1:0]   wait_left,
   output logic              seq_err
);

   generate
      if (T_RL < 1 || T_WL < 1 || T_BURST < 1 || T_WR < 1 ||
          T_RFC < 1 || T_XP < 1 || T_XS < 1 || T_RP < 1) begin : g_bad_timing
         $error("pdn_entry_gate: every timing count must be at least one cycle");
      end
      if (STORE_SPACING != 0 && STORE_SPACING != 1) begin : g_bad_variant
         $error("pdn_entry_gate: STORE_SPACING must be 0 or 1");
      end
   endgenerate

   logic            hist_vld;
   logic [SP_W-1:0] spacing;
   logic            legal;
   logic [SP_W-1:0] age;

   pdn_history #(
      .T_RL(T_RL), .T_WL(T_WL), .T_BURST(T_BURST), .T_WR(T_WR),
      .T_RFC(T_RFC), .T_XP(T_XP), .T_XS(T_XS), .T_RP(T_RP),
      .SP_W(SP_W), .AGE_CAP(SP_MAX), .STORE_SPACING(STORE_SPACING)
   ) u_hist (
      .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
      .hist_vld(hist_vld), .spacing(spacing), .legal(legal), .age(age)
   );

   pdn_entry_eval #(.SP_W(SP_W)) u_eval (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_kind(req_kind),
      .hist_vld(hist_vld), .spacing(spacing), .legal(legal), .age(age),
      .entry_ok(entry_ok), .wait_left(wait_left), .seq_err(seq_err)
   );

   // a waiting request that stays present counts down by one each cycle
   p_countdown_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_left > SP_W'(1) && !cmd_vld) ##1 (req_vld && req_kind != KIND_NONE)
      |-> (wait_left == $past(wait_left) - 1'b1));

endmodule

// File: tb/pdn_entry_gate_test.sv
module pdn_entry_gate_test;
   import pdn_gate_pkg::*;

   localparam int T_RL = 5, T_WL = 4, T_BURST = 4, T_WR = 6;
   localparam int T_RFC = 30, T_XP = 3, T_XS = 40, T_RP = 5;
   localparam int SP_RD  = T_RL + T_BURST + 1;
   localparam int SP_WR  = T_WL + T_BURST + T_WR;
   localparam int SP_WRA = SP_WR + 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_vld = 1'b0;
   logic [3:0] cmd_op = 4'h0;
   logic       req_vld = 1'b0;
   logic [1:0] req_kind = 2'd0;
   logic       entry_ok;
   logic [5:0] wait_left;
   logic       seq_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   pdn_entry_gate #(
      .T_RL(T_RL), .T_WL(T_WL), .T_BURST(T_BURST), .T_WR(T_WR),
      .T_RFC(T_RFC), .T_XP(T_XP), .T_XS(T_XS), .T_RP(T_RP)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
      .req_vld(req_vld), .req_kind(req_kind),
      .entry_ok(entry_ok), .wait_left(wait_left), .seq_err(seq_err)
   );

   task automatic probe(input logic v, input logic [1:0] kind, input logic exp_ok,
                        input int exp_wait, input logic exp_err, input string tag);
      req_vld  = v;
      req_kind = kind;
      #1;
      checks++;
      if (entry_ok !== exp_ok || wait_left !== 6'(exp_wait) || seq_err !== exp_err) begin
         fails++;
         $display("FAIL %s: ok=%0b wait=%0d err=%0b expected ok=%0b wait=%0d err=%0b",
                  tag, entry_ok, wait_left, seq_err, exp_ok, exp_wait, exp_err);
      end
   endtask

   // issue one command; returns one cycle later, at distance 1
   task automatic issue(input logic [3:0] op);
      req_vld = 1'b0;
      cmd_vld = 1'b1;
      cmd_op  = op;
      @(negedge clk);
      cmd_vld = 1'b0;
   endtask

   // scan distance 1..sp; wait_left must fall by one per cycle (R13)
   task automatic spacing_scan(input logic [3:0] op, input int sp, input string tag);
      issue(op);
      for (int d = 1; d <= sp; d++) begin
         probe(1'b1, 2'(d % 3), d >= sp, (d >= sp) ? 0 : sp - d, 1'b0, tag);
         @(negedge clk);
      end
      req_vld = 1'b0;
   endtask

   task automatic test_reset_state();
      probe(1'b0, 2'd0, 1'b0, 0, 1'b0, "R9 idle after reset");
      probe(1'b1, KIND_PDE_ACT, 1'b1, 0, 1'b0, "R1 active pd");
      probe(1'b1, KIND_PDE_PRE, 1'b1, 0, 1'b0, "R1 precharge pd");
      probe(1'b1, KIND_SRE, 1'b1, 0, 1'b0, "R1 self-refresh");
      @(negedge clk);
      req_vld = 1'b0;
   endtask

   task automatic test_illegal();
      issue(OP_ROW_OPEN);
      probe(1'b1, KIND_PDE_ACT, 1'b0, 0, 1'b1, "R8 after activate kind0");
      probe(1'b1, KIND_PDE_PRE, 1'b0, 0, 1'b1, "R8 after activate kind1");
      probe(1'b1, KIND_SRE, 1'b0, 0, 1'b1, "R8 after activate kind2");
      @(negedge clk);
      issue(4'hC);
      probe(1'b1, KIND_SRE, 1'b0, 0, 1'b1, "R8 after entry opcode");
      @(negedge clk);
      issue(4'hF);
      probe(1'b1, KIND_PDE_PRE, 1'b0, 0, 1'b1, "R8 after opcode 15");
      @(negedge clk);
      req_vld = 1'b0;
   endtask

   task automatic test_no_request();
      issue(OP_WR);
      probe(1'b1, KIND_NONE, 1'b0, 0, 1'b0, "R9 kind 3 while waiting");
      probe(1'b0, KIND_PDE_ACT, 1'b0, 0, 1'b0, "R9 no request while waiting");
      @(negedge clk);
      issue(OP_ROW_OPEN);
      probe(1'b1, KIND_NONE, 1'b0, 0, 1'b0, "R9 kind 3 after illegal");
      probe(1'b0, KIND_SRE, 1'b0, 0, 1'b0, "R9 no request after illegal");
      @(negedge clk);
      req_vld = 1'b0;
   endtask

   task automatic test_replace();
      issue(OP_RD);
      @(negedge clk);
      @(negedge clk);
      issue(OP_PRE_ONE);
      probe(1'b1, KIND_PDE_PRE, 1'b0, T_RP - 1, 1'b0, "R10 precharge replaces read");
      @(negedge clk);
      req_vld = 1'b0;
   endtask

   task automatic test_same_cycle();
      issue(OP_PRE_ALL);
      repeat (6) @(negedge clk);
      cmd_vld = 1'b1;
      cmd_op  = OP_ROW_OPEN;
      probe(1'b1, KIND_PDE_ACT, 1'b1, 0, 1'b0, "R11 same-cycle command ignored");
      @(negedge clk);
      cmd_vld = 1'b0;
      probe(1'b1, KIND_PDE_ACT, 1'b0, 0, 1'b1, "R11 command applies next cycle");
      @(negedge clk);
      req_vld = 1'b0;
   endtask

   task automatic test_saturate();
      issue(OP_PDX_ACT);
      repeat (100) @(negedge clk);
      probe(1'b1, KIND_SRE, 1'b1, 0, 1'b0, "R12 long idle after exit");
      @(negedge clk);
      issue(OP_SRX);
      req_vld = 1'b0;
      repeat (100) @(negedge clk);
      probe(1'b1, KIND_PDE_PRE, 1'b1, 0, 1'b0, "R12 long idle after self-refresh exit");
      @(negedge clk);
      req_vld = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      test_reset_state();
      spacing_scan(OP_RD, SP_RD, "R2 read");
      spacing_scan(OP_RD_AP, SP_RD, "R2 read auto-precharge");
      spacing_scan(OP_WR, SP_WR, "R3 write");
      spacing_scan(OP_WR_AP, SP_WRA, "R4 write auto-precharge");
      spacing_scan(OP_REF_ALL, T_RFC, "R5 refresh");
      spacing_scan(OP_PDX_ACT, T_XP, "R6 active pd exit");
      spacing_scan(OP_PDX_PRE, T_XP, "R6 precharge pd exit");
      spacing_scan(OP_SRX, T_XS, "R6 self-refresh exit");
      spacing_scan(OP_PRE_ONE, T_RP, "R7 single precharge");
      spacing_scan(OP_PRE_ALL, T_RP, "R7 all precharge");
      test_illegal();
      test_no_request();
      test_replace();
      test_same_cycle();
      test_saturate();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule